// File: doc/BRIEF.md
# Merging Write Buffer with Read Search

This block sits between a write-through cache and the next memory level and holds stores that have left the cache but have not yet reached memory. Each store names a block address, carries a full line of data words and a per-word write mask, and is accepted over a ready/valid handshake. A store whose block is already held in an unlocked, non-I/O entry is folded into that entry word by word instead of taking a new slot. Stores flagged as I/O never fold and are never folded into. Entries leave for memory oldest first over a second ready/valid handshake, one entry per transfer.

Read misses from the cache search the held entries by block address before memory is read. When no entry holds the block, the read may go to memory ahead of all pending writes. When an entry holds the requested word, the youngest such copy is forwarded. When the block is held but the word is not, the requester waits until the block has drained and then reads memory. A dirty victim line is written in as an ordinary store with a full mask, so the demand read proceeds first and the victim write follows.

The drain side is a two-state machine. In DRAIN_IDLE the memory port is quiet; the transition IDLE_TO_ISSUE is taken when at least one entry is held. In DRAIN_ISSUE the oldest entry is presented and locked against merging; the transition ISSUE_TO_IDLE is taken on the edge where memory accepts it, which also retires the entry. With no acceptance the machine holds in DRAIN_ISSUE.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: st_ready is 1, mem_valid is 0, and rd_match and rd_hit are 0 for any looked-up block.
- R2: A store to a block with no merge target takes a new entry; entries are offered on the memory port in acceptance order with the stored block address, the stored write mask, and data words equal to the written words (word w at bits w*32 upward) and zero for unwritten words.
- R3: A store whose block matches a held, unlocked, non-I/O entry updates that entry in place: only words whose mask bit is 1 take the new data, the entry mask becomes the OR of old and new masks, and no entry is added.
- R4: A store with st_io=1 never merges and no later store merges into an I/O entry; it always takes its own entry, so it stalls when the buffer is full.
- R5: st_ready is 1 exactly when the store has a merge target or fewer than ENTRIES entries are held; a store offered with st_ready=0 is not taken.
- R6: With rd_valid=1, rd_match is 1 when any held entry (including the one being drained) has the looked-up block; rd_hit is 1 when a matching entry has the mask bit of word rd_word set, and rd_data is that word from the youngest such entry.
- R7: rd_match is 0 for a block held in no entry, and both rd_match and rd_hit are 0 while rd_valid is 0.
- R8: While mem_valid is 1 and mem_ready is 0, mem_valid stays 1 and mem_blk_addr, mem_data and mem_wmask stay stable; the entry is retired on the edge where both are 1.
- R9: The entry on offer (mem_valid=1) is locked: a store to its block takes a new entry and the offered data and mask do not change.
- R10: mem_valid rises on the second rising edge after a store enters an empty, idle buffer; after each accepted transfer mem_valid is 0 for exactly one cycle (DRAIN_IDLE) before the next entry is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_blk_addr | input | BLK_W | Block address of the store |
| st_data | input | WORDS*DATA_W | Line data, word w at bits w*DATA_W upward |
| st_wmask | input | WORDS | Per-word write enable |
| st_io | input | 1 | Store targets I/O space, merging disabled |
| rd_valid | input | 1 | Read lookup request |
| rd_blk_addr | input | BLK_W | Block address of the read miss |
| rd_word | input | $clog2(WORDS) | Word index within the block |
| rd_match | output | 1 | Block is held in the buffer |
| rd_hit | output | 1 | Requested word can be forwarded |
| rd_data | output | DATA_W | Forwarded word |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_blk_addr | output | BLK_W | Block address of the offered entry |
| mem_data | output | WORDS*DATA_W | Line data of the offered entry |
| mem_wmask | output | WORDS | Word mask of the offered entry |

## Verification
The hardest situation to reach is a store arriving at the block of the entry currently on offer to memory while the buffer is full, where the lock, the merge search and the full stall all interact in one cycle. The stimulus holds mem_ready low so that the oldest entry sits in DRAIN_ISSUE, then fills the remaining slots and offers a locked-block store, a mergeable store and an I/O store to a held block in turn. A seeded random phase then draws addresses from a pool of six blocks with a mix of I/O flags and random memory back-pressure, so merges, locks, partial read matches and simultaneous push and retire recur many times against a bench-side model of the queue.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [0:0] {
        DRAIN_IDLE  = 1'b0,
        DRAIN_ISSUE = 1'b1
    } drain_state_e;

endpackage

// File: rtl/mwb_entry_store.sv
module mwb_entry_store #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int BLK_W   = 28,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic [BLK_W-1:0]   st_blk,
    input  logic [LINE_W-1:0]  st_line,
    input  logic [WORDS-1:0]   st_mask,
    input  logic               st_io,
    output logic               st_ready,
    input  logic               head_lock,
    input  logic               pop,
    output logic [ENTRIES-1:0] ent_valid,
    output logic [BLK_W-1:0]   ent_blk  [ENTRIES],
    output logic [LINE_W-1:0]  ent_line [ENTRIES],
    output logic [WORDS-1:0]   ent_mask [ENTRIES],
    output logic [PTR_W-1:0]   head_ptr,
    output logic [PTR_W:0]     occupancy
);

    logic [ENTRIES-1:0] ent_io;
    logic [PTR_W-1:0]   tail_ptr;
    logic [ENTRIES-1:0] merge_sel;
    logic               merge_any;
    logic [PTR_W-1:0]   merge_idx;
    logic               full;
    logic               push;
    logic               fold;
    logic [LINE_W-1:0]  fresh_line;

    // Merge target search: one candidate at most, since a block can be
    // held unlocked in only one non-I/O entry.
    always_comb begin
        merge_sel = '0;
        merge_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            merge_sel[i] = ent_valid[i] && !ent_io[i] && !st_io &&
                           (ent_blk[i] == st_blk) &&
                           !(head_lock && (PTR_W'(i) == head_ptr));
            if (merge_sel[i]) begin
                merge_idx = PTR_W'(i);
            end
        end
        merge_any = |merge_sel;
    end

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            fresh_line[w*DATA_W +: DATA_W] = st_mask[w] ? st_line[w*DATA_W +: DATA_W] : '0;
        end
    end

    assign full     = (occupancy == (PTR_W+1)'(ENTRIES));
    assign st_ready = merge_any || !full;
    assign push     = st_valid && st_ready && !merge_any;
    assign fold     = st_valid && st_ready && merge_any;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_io    <= '0;
            head_ptr  <= '0;
            tail_ptr  <= '0;
            occupancy <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_blk[i]  <= '0;
                ent_line[i] <= '0;
                ent_mask[i] <= '0;
            end
        end else begin
            if (fold) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (st_mask[w]) begin
                        ent_line[merge_idx][w*DATA_W +: DATA_W] <= st_line[w*DATA_W +: DATA_W];
                    end
                end
                ent_mask[merge_idx] <= ent_mask[merge_idx] | st_mask;
            end
            if (push) begin
                ent_valid[tail_ptr] <= 1'b1;
                ent_io[tail_ptr]    <= st_io;
                ent_blk[tail_ptr]   <= st_blk;
                ent_line[tail_ptr]  <= fresh_line;
                ent_mask[tail_ptr]  <= st_mask;
                tail_ptr            <= tail_ptr + 1'b1;
            end
            if (pop) begin
                ent_valid[head_ptr] <= 1'b0;
                head_ptr            <= head_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   occupancy <= occupancy + 1'b1;
                2'b01:   occupancy <= occupancy - 1'b1;
                default: occupancy <= occupancy;
            endcase
        end
    end

endmodule

// File: rtl/mwb_read_search.sv
module mwb_read_search #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int BLK_W   = 28,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [BLK_W-1:0]   ent_blk  [ENTRIES],
    input  logic [LINE_W-1:0]  ent_line [ENTRIES],
    input  logic [WORDS-1:0]   ent_mask [ENTRIES],
    input  logic [PTR_W-1:0]   head_ptr,
    input  logic               rd_valid,
    input  logic [BLK_W-1:0]   rd_blk,
    input  logic [SEL_W-1:0]   rd_word,
    output logic               rd_match,
    output logic               rd_hit,
    output logic [DATA_W-1:0]  rd_data
);

    // Scan from oldest to youngest so that the youngest covering copy wins.
    always_comb begin
        logic [PTR_W-1:0] idx;
        rd_match = 1'b0;
        rd_hit   = 1'b0;
        rd_data  = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            idx = head_ptr + PTR_W'(k);
            if (rd_valid && ent_valid[idx] && (ent_blk[idx] == rd_blk)) begin
                rd_match = 1'b1;
                if (ent_mask[idx][rd_word]) begin
                    rd_hit  = 1'b1;
                    rd_data = ent_line[idx][int'(rd_word)*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/mwb_drain_ctrl.sv
module mwb_drain_ctrl
    import mwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_work,
    input  logic mem_ready,
    output logic mem_valid,
    output logic pop,
    output logic head_lock
);

    drain_state_e state_q;
    drain_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRAIN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRAIN_IDLE:  if (have_work) state_d = DRAIN_ISSUE;
            DRAIN_ISSUE: if (mem_ready) state_d = DRAIN_IDLE;
            default:     state_d = DRAIN_IDLE;
        endcase
    end

    always_comb begin
        mem_valid = 1'b0;
        head_lock = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            DRAIN_IDLE: begin
                mem_valid = 1'b0;
            end
            DRAIN_ISSUE: begin
                mem_valid = 1'b1;
                head_lock = 1'b1;
                pop       = mem_ready;
            end
            default: begin
                mem_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int BLK_W   = 28,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [BLK_W-1:0]  st_blk_addr,
    input  logic [LINE_W-1:0] st_data,
    input  logic [WORDS-1:0]  st_wmask,
    input  logic              st_io,
    input  logic              rd_valid,
    input  logic [BLK_W-1:0]  rd_blk_addr,
    input  logic [SEL_W-1:0]  rd_word,
    output logic              rd_match,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [BLK_W-1:0]  mem_blk_addr,
    output logic [LINE_W-1:0] mem_data,
    output logic [WORDS-1:0]  mem_wmask
);

    logic [ENTRIES-1:0] ent_valid;
    logic [BLK_W-1:0]   ent_blk  [ENTRIES];
    logic [LINE_W-1:0]  ent_line [ENTRIES];
    logic [WORDS-1:0]   ent_mask [ENTRIES];
    logic [PTR_W-1:0]   head_ptr;
    logic [PTR_W:0]     occupancy;
    logic               head_lock;
    logic               pop;

    mwb_entry_store #(
        .ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_blk    (st_blk_addr),
        .st_line   (st_data),
        .st_mask   (st_wmask),
        .st_io     (st_io),
        .st_ready  (st_ready),
        .head_lock (head_lock),
        .pop       (pop),
        .ent_valid (ent_valid),
        .ent_blk   (ent_blk),
        .ent_line  (ent_line),
        .ent_mask  (ent_mask),
        .head_ptr  (head_ptr),
        .occupancy (occupancy)
    );

    mwb_read_search #(
        .ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)
    ) u_search (
        .ent_valid (ent_valid),
        .ent_blk   (ent_blk),
        .ent_line  (ent_line),
        .ent_mask  (ent_mask),
        .head_ptr  (head_ptr),
        .rd_valid  (rd_valid),
        .rd_blk    (rd_blk_addr),
        .rd_word   (rd_word),
        .rd_match  (rd_match),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data)
    );

    mwb_drain_ctrl u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_work (occupancy != '0),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .pop       (pop),
        .head_lock (head_lock)
    );

    assign mem_blk_addr = ent_blk[head_ptr];
    assign mem_data     = ent_line[head_ptr];
    assign mem_wmask    = ent_mask[head_ptr];

endmodule

// File: rtl/merge_write_buffer_checker.sv
module merge_write_buffer_checker #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int BLK_W   = 28,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int LINE_W = WORDS * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              st_io,
    input logic              rd_valid,
    input logic              rd_match,
    input logic              rd_hit,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [BLK_W-1:0]  mem_blk_addr,
    input logic [LINE_W-1:0] mem_data,
    input logic [WORDS-1:0]  mem_wmask,
    input logic [PTR_W:0]    occupancy
);

    assert_offer_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_blk_addr) &&
                                       $stable(mem_data) && $stable(mem_wmask)));

    assert_gap_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> !mem_valid);

    assert_hit_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_match);

    assert_quiet_lookup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!rd_match && !rd_hit));

    assert_stall_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> (occupancy == (PTR_W+1)'(ENTRIES)));

    assert_offer_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (occupancy != '0));

    assert_io_allocates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_io && !(mem_valid && mem_ready))
            |=> (occupancy == ($past(occupancy) + 1'b1)));

endmodule

bind merge_write_buffer merge_write_buffer_checker #(
    .ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .st_io        (st_io),
    .rd_valid     (rd_valid),
    .rd_match     (rd_match),
    .rd_hit       (rd_hit),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_blk_addr (mem_blk_addr),
    .mem_data     (mem_data),
    .mem_wmask    (mem_wmask),
    .occupancy    (occupancy)
);

// File: tb/merge_write_buffer_test.sv
module merge_write_buffer_test;

    localparam int N   = 4;
    localparam int W   = 4;
    localparam int DW  = 32;
    localparam int BW  = 28;
    localparam int LW  = W * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [BW-1:0] st_blk_addr = '0;
    logic [LW-1:0] st_data = '0;
    logic [W-1:0]  st_wmask = '0;
    logic          st_io = 1'b0;
    logic          rd_valid = 1'b0;
    logic [BW-1:0] rd_blk_addr = '0;
    logic [1:0]    rd_word = '0;
    logic          rd_match;
    logic          rd_hit;
    logic [DW-1:0] rd_data;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [BW-1:0] mem_blk_addr;
    logic [LW-1:0] mem_data;
    logic [W-1:0]  mem_wmask;

    int checks = 0;
    int fails  = 0;
    int idle_run = 0;
    bit finished = 1'b0;

    // bench model of the queue, index 0 is the oldest entry
    logic [BW-1:0] m_blk  [N];
    logic [LW-1:0] m_line [N];
    logic [W-1:0]  m_mask [N];
    bit            m_io   [N];
    int            m_cnt = 0;

    always #4 clk = ~clk;

    merge_write_buffer #(.ENTRIES(N), .WORDS(W), .DATA_W(DW), .BLK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_blk_addr(st_blk_addr),
        .st_data(st_data), .st_wmask(st_wmask), .st_io(st_io),
        .rd_valid(rd_valid), .rd_blk_addr(rd_blk_addr), .rd_word(rd_word),
        .rd_match(rd_match), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk_addr(mem_blk_addr),
        .mem_data(mem_data), .mem_wmask(mem_wmask)
    );

    task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                         input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] mk_line(input logic [DW-1:0] w3, input logic [DW-1:0] w2,
                                              input logic [DW-1:0] w1, input logic [DW-1:0] w0);
        return {w3, w2, w1, w0};
    endfunction

    function automatic int model_merge_idx(input logic [BW-1:0] blk, input bit io, input bit lock);
        for (int k = 0; k < m_cnt; k++) begin
            if (!m_io[k] && !io && m_blk[k] == blk && !(k == 0 && lock)) return k;
        end
        return -1;
    endfunction

    function automatic logic [DW+1:0] model_read(input logic [BW-1:0] blk, input logic [1:0] wd);
        logic [DW+1:0] r = '0; // {match, hit, data}
        for (int k = 0; k < m_cnt; k++) begin
            if (m_blk[k] == blk) begin
                r[DW+1] = 1'b1;
                if (m_mask[k][wd]) begin
                    r[DW] = 1'b1;
                    r[DW-1:0] = m_line[k][int'(wd)*DW +: DW];
                end
            end
        end
        return r;
    endfunction

    task automatic step();
        int mi;
        bit exp_ready, st_fire, mem_fire;
        logic [DW+1:0] er;
        logic [BW-1:0] s_blk;
        logic [LW-1:0] s_line;
        logic [W-1:0]  s_mask;
        bit            s_io;
        #1;
        mi = model_merge_idx(st_blk_addr, st_io, mem_valid);
        exp_ready = (mi >= 0) || (m_cnt < N);
        check(st_ready === exp_ready, "R5 st_ready", LW'(st_ready), LW'(exp_ready));
        if (rd_valid) begin
            er = model_read(rd_blk_addr, rd_word);
            check(rd_match === er[DW+1], "R6 R7 rd_match", LW'(rd_match), LW'(er[DW+1]));
            check(rd_hit === er[DW], "R6 rd_hit", LW'(rd_hit), LW'(er[DW]));
            if (er[DW]) check(rd_data === er[DW-1:0], "R6 rd_data", LW'(rd_data), LW'(er[DW-1:0]));
        end else begin
            check(!rd_match && !rd_hit, "R7 idle lookup", LW'({rd_match, rd_hit}), '0);
        end
        if (mem_valid) begin
            check(m_cnt > 0, "R2 offer while empty", LW'(m_cnt), 1);
            check(mem_blk_addr === m_blk[0], "R2 R8 mem_blk_addr", LW'(mem_blk_addr), LW'(m_blk[0]));
            check(mem_wmask === m_mask[0], "R2 R8 mem_wmask", LW'(mem_wmask), LW'(m_mask[0]));
            check(mem_data === m_line[0], "R2 R8 mem_data", mem_data, m_line[0]);
            idle_run = 0;
        end else if (m_cnt > 0) begin
            idle_run++;
            check(idle_run <= 1, "R10 idle gap", LW'(idle_run), 1);
        end else begin
            idle_run = 0;
        end
        st_fire  = st_valid && exp_ready;
        mem_fire = mem_valid && mem_ready;
        s_blk = st_blk_addr; s_line = st_data; s_mask = st_wmask; s_io = st_io;
        @(posedge clk);
        if (st_fire) begin
            if (mi >= 0) begin
                for (int w = 0; w < W; w++)
                    if (s_mask[w]) m_line[mi][w*DW +: DW] = s_line[w*DW +: DW];
                m_mask[mi] = m_mask[mi] | s_mask;
            end else begin
                m_blk[m_cnt] = s_blk;
                m_mask[m_cnt] = s_mask;
                m_io[m_cnt] = s_io;
                for (int w = 0; w < W; w++)
                    m_line[m_cnt][w*DW +: DW] = s_mask[w] ? s_line[w*DW +: DW] : '0;
                m_cnt++;
            end
        end
        if (mem_fire) begin
            for (int k = 0; k < N - 1; k++) begin
                m_blk[k] = m_blk[k+1]; m_line[k] = m_line[k+1];
                m_mask[k] = m_mask[k+1]; m_io[k] = m_io[k+1];
            end
            m_cnt--;
        end
        @(negedge clk);
    endtask

    task automatic drive_store(input logic [BW-1:0] blk, input logic [W-1:0] mask,
                               input logic [LW-1:0] line, input bit io);
        st_valid = 1'b1; st_blk_addr = blk; st_wmask = mask; st_data = line; st_io = io;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd51966));
        rd_valid = 1'b1; rd_blk_addr = 28'h10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(st_ready === 1'b1, "R1 st_ready", LW'(st_ready), 1);
        check(mem_valid === 1'b0, "R1 mem_valid", LW'(mem_valid), 0);
        check(!rd_match && !rd_hit, "R1 lookup", LW'({rd_match, rd_hit}), 0);

        // store into empty buffer, then fold into it before it is offered
        drive_store(28'h10, 4'b0001, mk_line(0, 0, 0, 32'hA0), 1'b0);
        step();
        drive_store(28'h10, 4'b0010, mk_line(0, 0, 32'hA1, 0), 1'b0);
        #1 check(mem_valid === 1'b0, "R10 not yet offered", LW'(mem_valid), 0);
        step();
        drive_store(28'h10, 4'b0100, mk_line(0, 32'hA2, 0, 0), 1'b0);
        #1 check(mem_valid === 1'b1, "R10 offered on second edge", LW'(mem_valid), 1);
        check(mem_wmask === 4'b0011, "R3 folded mask", LW'(mem_wmask), 4'b0011);
        check(mem_data === mk_line(0, 0, 32'hA1, 32'hA0), "R3 folded data", mem_data,
              mk_line(0, 0, 32'hA1, 32'hA0));
        step();
        drive_store(28'h20, 4'b1111, mk_line(32'hB3, 32'hB2, 32'hB1, 32'hB0), 1'b0);
        step();
        drive_store(28'h30, 4'b0001, mk_line(0, 0, 0, 32'hC0), 1'b0);
        step();
        drive_store(28'h40, 4'b0001, mk_line(0, 0, 0, 32'hD0), 1'b0);
        #1 check(st_ready === 1'b0, "R5 full stall", LW'(st_ready), 0);
        step();
        drive_store(28'h20, 4'b0001, mk_line(0, 0, 0, 32'hBB), 1'b0);
        #1 check(st_ready === 1'b1, "R5 fold while full", LW'(st_ready), 1);
        step();
        drive_store(28'h20, 4'b0001, mk_line(0, 0, 0, 32'hEE), 1'b1);
        #1 check(st_ready === 1'b0, "R4 io never folds", LW'(st_ready), 0);
        step();
        st_valid = 1'b0;
        rd_blk_addr = 28'h10; rd_word = 2'd2;
        #1 check(rd_hit === 1'b1 && rd_data === 32'hA2, "R6 forward", LW'(rd_data), 32'hA2);
        check(mem_wmask === 4'b0011, "R9 locked entry unchanged", LW'(mem_wmask), 4'b0011);
        step();
        rd_word = 2'd3;
        #1 check(rd_match === 1'b1 && rd_hit === 1'b0, "R6 partial match",
                 LW'({rd_match, rd_hit}), 2'b10);
        step();
        rd_blk_addr = 28'h99;
        #1 check(rd_match === 1'b0, "R7 absent block", LW'(rd_match), 0);
        step();
        rd_blk_addr = 28'h20; rd_word = 2'd0;
        #1 check(rd_data === 32'hBB, "R3 folded word forwarded", LW'(rd_data), 32'hBB);
        step();
        mem_ready = 1'b1;
        repeat (12) step();

        // I/O stores to a held block take their own entries
        mem_ready = 1'b0;
        drive_store(28'h50, 4'b0001, mk_line(0, 0, 0, 32'h50), 1'b0);
        step();
        drive_store(28'h50, 4'b0010, mk_line(0, 0, 32'h51, 0), 1'b1);
        step();
        drive_store(28'h50, 4'b0100, mk_line(0, 32'h52, 0, 0), 1'b0);
        step();
        st_valid = 1'b0;
        rd_blk_addr = 28'h50; rd_word = 2'd1;
        step();
        mem_ready = 1'b1;
        repeat (10) step();

        // seeded random phase
        for (int c = 0; c < 4000; c++) begin
            st_valid    = ($urandom % 10) < 6;
            st_blk_addr = 28'h100 + BW'($urandom % 6);
            st_wmask    = W'($urandom % 15) + 1'b1;
            st_data     = {$urandom, $urandom, $urandom, $urandom};
            st_io       = ($urandom % 8) == 0;
            rd_valid    = ($urandom % 4) != 0;
            rd_blk_addr = 28'h100 + BW'($urandom % 6);
            rd_word     = 2'($urandom % 4);
            mem_ready   = ($urandom % 2) == 0;
            step();
        end
        st_valid = 1'b0;
        mem_ready = 1'b1;
        repeat (12) step();
        check(m_cnt == 0 && mem_valid === 1'b0, "R2 drained", LW'(mem_valid), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule